// File: doc/BRIEF.md
# Bus-Mapped Periodic Interval Timer

The block is a periodic timer that sits on a simple 16-bit register bus with strobe, cycle, write-enable and acknowledge. Software sets up a control word and a modulo value, then reads a live count. A prescaler divides the clock by a power of two chosen by a 4-bit select field. Each prescaler step advances a counter that runs from 1 up to the modulo value and then reloads to 1. Every reload sets a sticky rollover flag, produces a one-cycle pulse on a timer output and, when enabled, raises an interrupt.

Several timers can share one timebase. A timer in master mode puts its prescaler step on a count-enable strobe output. A timer in slave mode ignores its own prescaler and advances on a sync input, which is normally wired to a master's strobe. An asynchronous reset, whose active level is a parameter, and a synchronous active-high reset both return every register to its reset value.

Top module: `intv_timer`

## Requirements
- R1: After either reset the control word reads 0x4000, the modulo reads 0, the count reads 1 and the interrupt output is 0.
- R2: An access is acknowledged one clock after strobe and cycle are both seen high. The acknowledge lasts exactly one cycle, so a strobe held high produces acknowledges in alternate cycles. Read data is valid while the acknowledge is high.
- R3: The control word is at word address 0. Bit 0 is the counter enable, bit 1 the interrupt enable, bit 2 the rollover flag, bits 11:8 the prescaler select and bit 15 slave mode. Bit 14 always reads 1 and every other bit reads 0. Writing 0xFFFE therefore reads back 0xCF02.
- R4: The modulo register is at word address 1 and every one of its 16 bits can be read and written.
- R5: The count is at word address 2 and is read-only. A write to it leaves the value unchanged.
- R6: In master mode with the counter enabled, the prescaler produces one step every 2^select clocks. The first rollover comes modulo × 2^select clocks after the clock edge that accepts the enabling write.
- R7: The count advances by 1 on each step, and on the step where it equals the modulo it reloads to 1. A modulo of 0 gives a period of 65536 steps.
- R8: A rollover sets the flag and produces a one-cycle high pulse on the timer output. The flag stays set until a control write with bit 2 at 1. A control write with bit 2 at 0 leaves it set.
- R9: The interrupt output is high exactly when the flag and the interrupt enable are both set. The flag is still recorded while the interrupt enable is 0.
- R10: A master that is enabled drives the count-enable strobe high for one cycle per prescaler step. A timer in slave mode keeps the strobe low.
- R11: In slave mode the counter advances once for each clock in which the sync input is high, and the prescaler has no effect.
- R12: While the counter enable is 0, the count holds at 1 and the prescaler holds at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_i | input | 1 | Asynchronous reset; active level set by RST_LVL (default low) |
| srst_i | input | 1 | Synchronous reset, active high |
| bus_adr_i | input | 2 | Word address: 0 control, 1 modulo, 2 count |
| bus_dat_i | input | 16 | Write data |
| bus_dat_o | output | 16 | Read data, valid with the acknowledge |
| bus_we_i | input | 1 | Write enable |
| bus_stb_i | input | 1 | Strobe |
| bus_cyc_i | input | 1 | Cycle valid |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| irq_o | output | 1 | Interrupt: flag AND interrupt enable |
| tick_o | output | 1 | One-cycle pulse on each rollover |
| sync_i | input | 1 | Count strobe used in slave mode |
| sync_o | output | 1 | Count-enable strobe driven in master mode |

## Verification
The bench builds the timer with the default parameters: an active-low asynchronous reset and a 4-bit prescaler select, giving division by up to 2^15. With these values it runs prescaler selects 0, 1 and 2, which shows how the period scales with the exponent. A modulo of 0 brings the full 65536-clock period within the run time, so the wrap of the 16-bit counter is tested. Driving the sync input directly steps a slave one count at a time, and the count is read back after each step.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int DW       = 16;
  localparam int AW       = 2;
  localparam int PSEL_W   = 4;
  localparam int PRE_W    = (1 << PSEL_W) - 1;

  localparam logic [AW-1:0] ADR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADR_MOD  = 2'd1;
  localparam logic [AW-1:0] ADR_CNT  = 2'd2;

  localparam int BIT_EN    = 0;
  localparam int BIT_IEN   = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_SLAVE = 15;

  typedef struct packed {
    logic              slave;
    logic [PSEL_W-1:0] psel;
    logic              ien;
    logic              en;
  } ctrl_t;

  function automatic logic [DW-1:0] ctrl_pack(input ctrl_t c, input logic flag);
    return {c.slave, 1'b1, 2'b00, c.psel, 5'b00000, flag, c.ien, c.en};
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [DW-1:0] w);
    ctrl_t c;
    c.slave = w[BIT_SLAVE];
    c.psel  = w[11:8];
    c.ien   = w[BIT_IEN];
    c.en    = w[BIT_EN];
    return c;
  endfunction

  function automatic logic [PRE_W-1:0] presc_mask(input logic [PSEL_W-1:0] sel);
    return PRE_W'((PRE_W+1)'(1) << sel) - PRE_W'(1);
  endfunction
endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler
  import intv_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_a,
  input  logic              srst_i,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;

  assign mask   = presc_mask(sel_i);
  assign tick_o = run_i & ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or posedge rst_a) begin
    if (rst_a)        pcnt_q <= '0;
    else if (srst_i)  pcnt_q <= '0;
    else if (!run_i)  pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + PRE_W'(1);
  end

  // R6
  presc_run_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    tick_o |-> run_i);
  // R12
  presc_idle_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    !run_i |=> (pcnt_q == '0));
endmodule

// File: rtl/intv_counter.sv
module intv_counter
  import intv_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_a,
  input  logic          srst_i,
  input  logic          en_i,
  input  logic          step_i,
  input  logic [DW-1:0] mod_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i & step_i & (cnt_q == mod_i);

  always_ff @(posedge clk_i or posedge rst_a) begin
    if (rst_a)               cnt_q <= DW'(1);
    else if (srst_i)         cnt_q <= DW'(1);
    else if (!en_i)          cnt_q <= DW'(1);
    else if (wrap_o)         cnt_q <= DW'(1);
    else if (step_i)         cnt_q <= cnt_q + DW'(1);
  end

  // R7
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    wrap_o |=> (cnt_q == DW'(1)));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    !en_i |=> (cnt_q == DW'(1)));
  // R7
  step_move_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    (en_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/intv_bus_regs.sv
module intv_bus_regs
  import intv_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_a,
  input  logic          srst_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] wdat_i,
  input  logic          we_i,
  input  logic          stb_i,
  input  logic          cyc_i,
  input  logic          wrap_i,
  input  logic [DW-1:0] cnt_i,
  output logic [DW-1:0] rdat_o,
  output logic          ack_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] mod_o,
  output logic          flag_o
);
  logic          ack_q, flag_q;
  logic [DW-1:0] rdat_q, mod_q, rd_mux;
  ctrl_t         ctrl_q;
  logic          req, wr_ctrl, wr_mod, clr_flag, flag_d;

  assign req      = stb_i & cyc_i & ~ack_q;
  assign wr_ctrl  = req & we_i & (adr_i == ADR_CTRL);
  assign wr_mod   = req & we_i & (adr_i == ADR_MOD);
  assign clr_flag = wr_ctrl & wdat_i[BIT_FLAG];
  assign flag_d   = wrap_i ? 1'b1 : (clr_flag ? 1'b0 : flag_q);

  always_comb begin
    unique case (adr_i)
      ADR_CTRL: rd_mux = ctrl_pack(ctrl_q, flag_q);
      ADR_MOD:  rd_mux = mod_q;
      ADR_CNT:  rd_mux = cnt_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or posedge rst_a) begin
    if (rst_a) begin
      ack_q <= 1'b0; flag_q <= 1'b0; rdat_q <= '0; mod_q <= '0; ctrl_q <= '0;
    end else if (srst_i) begin
      ack_q <= 1'b0; flag_q <= 1'b0; rdat_q <= '0; mod_q <= '0; ctrl_q <= '0;
    end else begin
      ack_q  <= req;
      flag_q <= flag_d;
      if (req)     rdat_q <= rd_mux;
      if (wr_ctrl) ctrl_q <= ctrl_unpack(wdat_i);
      if (wr_mod)  mod_q  <= wdat_i;
    end
  end

  assign rdat_o = rdat_q;
  assign ack_o  = ack_q;
  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;
  assign flag_o = flag_q;

  // R2
  ack_single_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    ack_q |=> !ack_q);
  // R2
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    $rose(ack_q) |-> $past(stb_i && cyc_i));
  // R8
  flag_src_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    $rose(flag_q) |-> $past(wrap_i));
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter logic RST_LVL = 1'b0
) (
  input  logic          clk_i,
  input  logic          arst_i,
  input  logic          srst_i,
  input  logic [1:0]    bus_adr_i,
  input  logic [15:0]   bus_dat_i,
  output logic [15:0]   bus_dat_o,
  input  logic          bus_we_i,
  input  logic          bus_stb_i,
  input  logic          bus_cyc_i,
  output logic          bus_ack_o,
  output logic          irq_o,
  output logic          tick_o,
  input  logic          sync_i,
  output logic          sync_o
);
  logic          rst_a;
  ctrl_t         ctrl;
  logic [DW-1:0] mod_val, cnt_val;
  logic          flag, wrap, presc_tick, step, presc_run, tick_q;

  if (RST_LVL) begin : g_rst_hi
    assign rst_a = arst_i;
  end else begin : g_rst_lo
    assign rst_a = ~arst_i;
  end

  intv_bus_regs u_regs (
    .clk_i(clk_i), .rst_a(rst_a), .srst_i(srst_i),
    .adr_i(bus_adr_i), .wdat_i(bus_dat_i), .we_i(bus_we_i),
    .stb_i(bus_stb_i), .cyc_i(bus_cyc_i),
    .wrap_i(wrap), .cnt_i(cnt_val),
    .rdat_o(bus_dat_o), .ack_o(bus_ack_o),
    .ctrl_o(ctrl), .mod_o(mod_val), .flag_o(flag)
  );

  assign presc_run = ctrl.en & ~ctrl.slave;

  intv_prescaler u_presc (
    .clk_i(clk_i), .rst_a(rst_a), .srst_i(srst_i),
    .run_i(presc_run), .sel_i(ctrl.psel), .tick_o(presc_tick)
  );

  assign step = ctrl.slave ? sync_i : presc_tick;

  intv_counter u_cnt (
    .clk_i(clk_i), .rst_a(rst_a), .srst_i(srst_i),
    .en_i(ctrl.en), .step_i(step), .mod_i(mod_val),
    .cnt_o(cnt_val), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or posedge rst_a) begin
    if (rst_a)       tick_q <= 1'b0;
    else if (srst_i) tick_q <= 1'b0;
    else             tick_q <= wrap;
  end

  assign tick_o = tick_q;
  assign irq_o  = flag & ctrl.ien;
  assign sync_o = presc_tick;

  // R10
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    ctrl.slave |-> !sync_o);
  // R8
  tick_flag_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    tick_o |-> flag);
  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_a || srst_i)
    irq_o |-> (ctrl.ien && flag));
endmodule

// File: tb/intv_timer_bench.sv
module intv_timer_bench;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        srst = 1'b0;
  logic [1:0]  adr = '0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic        we = 1'b0, stb = 1'b0, cyc = 1'b0;
  logic        ack, irq, tick, sync_in = 1'b0, sync_out;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  intv_timer u_intv_timer (
    .clk_i(clk), .arst_i(arst_n), .srst_i(srst),
    .bus_adr_i(adr), .bus_dat_i(wdat), .bus_dat_o(rdat),
    .bus_we_i(we), .bus_stb_i(stb), .bus_cyc_i(cyc), .bus_ack_o(ack),
    .irq_o(irq), .tick_o(tick), .sync_i(sync_in), .sync_o(sync_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    adr = a; wdat = d; we = 1'b1; stb = 1'b1; cyc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stb = 1'b0; cyc = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    adr = a; we = 1'b0; stb = 1'b1; cyc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = rdat;
    stb = 1'b0; cyc = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [15:0] exp, input string req);
    logic [15:0] v;
    bus_rd(a, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic t_reset_vals(input string req);
    expect_rd(2'd0, 16'h4000, req);
    expect_rd(2'd1, 16'h0000, req);
    expect_rd(2'd2, 16'h0001, req);
    chk(irq == 1'b0, req, irq, 0);
  endtask

  task automatic t_ack;
    @(negedge clk);
    chk(ack == 1'b0, "R2 idle", ack, 0);
    adr = 2'd1; we = 1'b0; stb = 1'b1; cyc = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ack == 1'b1, "R2 first ack", ack, 1);
    @(posedge clk); @(negedge clk);
    chk(ack == 1'b0, "R2 single cycle", ack, 0);
    @(posedge clk); @(negedge clk);
    chk(ack == 1'b1, "R2 held strobe re-ack", ack, 1);
    stb = 1'b0; cyc = 1'b0;
  endtask

  task automatic t_regs;
    bus_wr(2'd0, 16'hFFFE);
    expect_rd(2'd0, 16'hCF02, "R3 mask");
    bus_wr(2'd0, 16'h0000);
    expect_rd(2'd0, 16'h4000, "R3 clear");
    bus_wr(2'd1, 16'h5555);
    expect_rd(2'd1, 16'h5555, "R4 5555");
    bus_wr(2'd1, 16'hAAAA);
    expect_rd(2'd1, 16'hAAAA, "R4 AAAA");
    bus_wr(2'd2, 16'hFFFE);
    expect_rd(2'd2, 16'h0001, "R5 count read-only");
  endtask

  task automatic t_period(input int psel, input int modv);
    int k = 0;
    int exp_k;
    exp_k = ((modv == 0) ? 65536 : modv) * (1 << psel);
    bus_wr(2'd0, 16'h0004);
    bus_wr(2'd1, 16'(modv));
    bus_wr(2'd0, 16'h0003 | 16'(psel << 8));
    while (k < 70000) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (irq) break;
    end
    chk(k == exp_k, "R6 R7 period", k, exp_k);
    chk(tick == 1'b1, "R8 tick with rollover", tick, 1);
    @(posedge clk); @(negedge clk);
    chk(tick == 1'b0, "R8 tick one cycle", tick, 0);
  endtask

  task automatic t_flag;
    t_period(0, 4);
    bus_wr(2'd0, 16'h0002);
    expect_rd(2'd0, 16'h4006, "R8 write 0 keeps flag");
    chk(irq == 1'b1, "R9 irq with flag", irq, 1);
    expect_rd(2'd2, 16'h0001, "R12 held while disabled");
    bus_wr(2'd0, 16'h0004);
    expect_rd(2'd0, 16'h4000, "R8 write 1 clears flag");
    chk(irq == 1'b0, "R9 irq drops", irq, 0);
  endtask

  task automatic t_irq_mask;
    bus_wr(2'd1, 16'd4);
    bus_wr(2'd0, 16'h0001);
    repeat (6) begin @(posedge clk); @(negedge clk); end
    chk(irq == 1'b0, "R9 masked", irq, 0);
    expect_rd(2'd0, 16'h4005, "R9 flag recorded");
    bus_wr(2'd0, 16'h0004);
  endtask

  task automatic t_master_sync;
    int pulses = 0;
    bus_wr(2'd1, 16'd0);
    bus_wr(2'd0, 16'h0101);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (sync_out) pulses++;
    end
    chk(pulses == 10, "R10 master strobe rate", pulses, 10);
    bus_wr(2'd0, 16'h0004);
  endtask

  task automatic t_slave;
    int seen = 0;
    bus_wr(2'd1, 16'd3);
    bus_wr(2'd0, 16'h8003);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (sync_out) seen++;
    end
    chk(seen == 0, "R10 slave strobe low", seen, 0);
    expect_rd(2'd2, 16'd1, "R11 no prescaler steps");
    for (int s = 2; s <= 3; s++) begin
      @(negedge clk); sync_in = 1'b1;
      @(negedge clk); sync_in = 1'b0;
      expect_rd(2'd2, 16'(s), "R11 sync step");
    end
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    chk(irq == 1'b1, "R11 rollover on sync", irq, 1);
    expect_rd(2'd2, 16'd1, "R7 reload to 1");
    bus_wr(2'd0, 16'h0004);
  endtask

  task automatic t_srst;
    bus_wr(2'd1, 16'h1234);
    bus_wr(2'd0, 16'h8F03);
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    t_reset_vals("R1 sync reset");
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #3 arst_n = 1'b0;
    #10 arst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset_vals("R1 async reset");
    t_ack();
    t_regs();
    t_period(0, 4);
    t_period(2, 3);
    t_period(1, 5);
    t_flag();
    t_irq_mask();
    t_master_sync();
    t_slave();
    t_period(0, 0);
    t_srst();
    finish_run();
  end
endmodule